// File: doc/BRIEF.md
# Master Serial Result Transmitter

This block sends an 18-bit conversion result over a serial link. The block generates the serial clock itself and marks each frame with a frame-sync output. The conversion sequencer gives it a pulse at the start of every conversion and a pulse, with the result word, when the conversion ends. The block then shifts one frame out, most significant bit first. While a frame is in flight, `tx_busy_o` is high, so the sequencer can hold its own busy indication until the read is done.

Two read timings are available. In read-after-convert mode, the end-of-conversion pulse starts a frame that carries the new result. The serial clock in this mode is slowed by a two-bit divider code. In read-during-convert mode, the block keeps the last result it received. The start-of-conversion pulse sends that stored result while the next conversion runs, and the fastest clock is always used. Per-frame selects choose the output coding (straight binary or twos complement) and the active level of the frame sync. The chip select gates the outputs and the start of frames.

Top module: `ser_result_tx`

## Requirements
- R1: Each frame has exactly 18 rising edges of `sclk_o`. The `sdo_o` values taken at those edges, first to last, are the loaded word from bit 17 down to bit 0. `sclk_o` is low outside a frame and at the end of a frame.
- R2: When `coding_i` is 0 at frame start, bit 17 of the result is inverted before it is sent (twos complement). When `coding_i` is 1, the result is sent unchanged (straight binary).
- R3: `sync_o` equals `~sync_pol_i` during a frame and `sync_pol_i` outside it. A frame lasts 37·H system cycles, where H is the half period in cycles. The first rising edge of `sclk_o` comes H cycles after the start edge. The last falling edge is followed by H cycles of sync still asserted.
- R4: With `rdc_i` = 1, a `conv_start_i` pulse starts a frame carrying the result stored by the most recent `result_valid_i` pulse. In this mode, `result_valid_i` only stores the result and starts no frame.
- R5: With `rdc_i` = 0, a `result_valid_i` pulse starts a frame carrying `result_i` as sampled on that edge. In this mode, `conv_start_i` has no effect.
- R6: With `rdc_i` = 0, the half period H equals BASE_HALF·2^`div_i`. With the default BASE_HALF = 2, codes 0..3 give H = 2, 4, 8, 16 cycles.
- R7: With `rdc_i` = 1, H equals BASE_HALF whatever `div_i` holds.
- R8: `sdo_o` never changes in the same system cycle as `sclk_o` changes level, so data is stable across both clock edges.
- R9: `pins_en_o` is the inverse of `cs_n_i`, and low means all three serial outputs are released to high impedance. While `cs_n_i` is high, start pulses are ignored.
- R10: A start pulse that arrives while `tx_busy_o` is high is ignored. The running frame completes unchanged. `tx_busy_o` is high from the start edge until the frame ends.
- R11: After reset, `sclk_o` is 0, `tx_busy_o` is 0, `sync_o` is at its idle level, and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| result_i | input | 18 | Conversion result from the sequencer |
| result_valid_i | input | 1 | One-cycle pulse: conversion ended, result_i valid |
| conv_start_i | input | 1 | One-cycle pulse: a conversion has started |
| cs_n_i | input | 1 | Active-low chip select |
| coding_i | input | 1 | 1 = straight binary, 0 = twos complement |
| sync_pol_i | input | 1 | 0 = sync active high, 1 = sync active low |
| rdc_i | input | 1 | 1 = send previous result during conversion, 0 = send new result after it |
| div_i | input | 2 | Clock divider code, used in read-after-convert only |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame sync |
| pins_en_o | output | 1 | Output drive enable for sclk/sdo/sync |
| tx_busy_o | output | 1 | Frame in progress |

## Verification
The bench checks that the divider code changes the period only in read-after-convert mode. A design that applied it in both modes would stretch the during-conversion frames. It checks that coding inverts exactly the top bit. It checks that read-during-convert sends the stored result rather than the word on the bus; a design that mixed these up would send the wrong word. It also checks that a result pulse arriving mid-frame neither restarts the frame nor corrupts the shift register, that the frame holds exactly 18 clocks with sync spanning 37 half periods, and that data never moves on the same cycle as a clock edge. A design with an off-by-one in the bit count or a shift on the falling edge fails these.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_TAIL = 2'd3
    } tx_state_e;

endpackage

// File: rtl/ser_tx_capture.sv
module ser_tx_capture #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result_i,
    input  logic              result_valid_i,
    input  logic              rdc_i,
    input  logic              coding_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] last_q;
    logic [DATA_W-1:0] raw;

    // holds the most recent result for read-during-convert frames
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (result_valid_i) begin
            last_q <= result_i;
        end
    end

    always_comb begin
        raw    = rdc_i ? last_q : result_i;
        word_o = {raw[DATA_W-1] ^ ~coding_i, raw[DATA_W-2:0]};
    end

endmodule

// File: rtl/ser_tx_divsel.sv
module ser_tx_divsel #(
    parameter int BASE_HALF = 2,
    parameter int DIV_W     = 2,
    parameter int CNT_W     = 5
) (
    input  logic             rdc_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [CNT_W-1:0] half_o
);

    localparam int N_CODES = 1 << DIV_W;

    logic [CNT_W-1:0] half_tab [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_tab
        assign half_tab[g] = CNT_W'(BASE_HALF << g);
    end

    always_comb begin
        if (rdc_i) begin
            half_o = CNT_W'(BASE_HALF);
        end else begin
            half_o = half_tab[div_i];
        end
    end

endmodule

// File: rtl/ser_tx_fsm.sv
module ser_tx_fsm
    import ser_tx_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [CNT_W-1:0]  half_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              active_o
);

    localparam int BIT_W = $clog2(DATA_W);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  half_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic              phase_end;
    logic              last_bit;

    assign phase_end = (cnt_q == CNT_W'(half_q - 1'b1));
    assign last_bit  = (bit_q == BIT_W'(DATA_W - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_LOW;
            ST_LOW:  if (phase_end) state_d = ST_HIGH;
            ST_HIGH: if (phase_end) state_d = last_bit ? ST_TAIL : ST_LOW;
            ST_TAIL: if (phase_end) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            half_q  <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else if (state_q == ST_IDLE) begin
            cnt_q <= '0;
            if (start_i) begin
                shreg_q <= word_i;
                half_q  <= half_i;
                bit_q   <= '0;
            end
        end else begin
            cnt_q <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            // next bit appears one cycle after the falling edge
            if (state_q == ST_LOW && cnt_q == '0 && bit_q != '0) begin
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            end
            if (state_q == ST_HIGH && phase_end && !last_bit) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        sclk_o   = (state_q == ST_HIGH);
        sdo_o    = shreg_q[DATA_W-1];
        active_o = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/ser_result_tx.sv
module ser_result_tx #(
    parameter int DATA_W    = 18,
    parameter int DIV_W     = 2,
    parameter int BASE_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result_i,
    input  logic              result_valid_i,
    input  logic              conv_start_i,
    input  logic              cs_n_i,
    input  logic              coding_i,
    input  logic              sync_pol_i,
    input  logic              rdc_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              sync_o,
    output logic              pins_en_o,
    output logic              tx_busy_o
);

    localparam int MAX_HALF = BASE_HALF << ((1 << DIV_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic [DATA_W-1:0] word;
    logic [CNT_W-1:0]  half;
    logic              start;
    logic              active;

    assign start = !cs_n_i && (rdc_i ? conv_start_i : result_valid_i);

    ser_tx_capture #(.DATA_W(DATA_W)) u_capture (
        .clk            (clk),
        .rst_n          (rst_n),
        .result_i       (result_i),
        .result_valid_i (result_valid_i),
        .rdc_i          (rdc_i),
        .coding_i       (coding_i),
        .word_o         (word)
    );

    ser_tx_divsel #(.BASE_HALF(BASE_HALF), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_divsel (
        .rdc_i  (rdc_i),
        .div_i  (div_i),
        .half_o (half)
    );

    ser_tx_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .word_i   (word),
        .half_i   (half),
        .sclk_o   (sclk_o),
        .sdo_o    (sdo_o),
        .active_o (active)
    );

    always_comb begin
        sync_o    = active ^ sync_pol_i;
        pins_en_o = !cs_n_i;
        tx_busy_o = active;
    end

endmodule

// File: rtl/ser_result_tx_chk.sv
module ser_result_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic sync_pol_i,
    input logic sclk_o,
    input logic sdo_o,
    input logic sync_o,
    input logic tx_busy_o
);

    a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_o) |-> $stable(sdo_o));

    a_r1_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> tx_busy_o);

    a_r1_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy_o) |-> !sclk_o);

    a_r3_sync_active: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> (sync_o != sync_pol_i));

    a_r9_start_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy_o) |-> $past(!cs_n_i));

endmodule

bind ser_result_tx ser_result_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .sync_pol_i (sync_pol_i),
    .sclk_o     (sclk_o),
    .sdo_o      (sdo_o),
    .sync_o     (sync_o),
    .tx_busy_o  (tx_busy_o)
);

// File: tb/test_ser_result_tx.sv
module test_ser_result_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] result_i = '0;
    logic        result_valid_i = 1'b0;
    logic        conv_start_i = 1'b0;
    logic        cs_n_i = 1'b0;
    logic        coding_i = 1'b1;
    logic        sync_pol_i = 1'b0;
    logic        rdc_i = 1'b0;
    logic [1:0]  div_i = '0;
    logic        sclk_o, sdo_o, sync_o, pins_en_o, tx_busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ser_result_tx i_ser_result_tx (
        .clk(clk), .rst_n(rst_n), .result_i(result_i),
        .result_valid_i(result_valid_i), .conv_start_i(conv_start_i),
        .cs_n_i(cs_n_i), .coding_i(coding_i), .sync_pol_i(sync_pol_i),
        .rdc_i(rdc_i), .div_i(div_i), .sclk_o(sclk_o), .sdo_o(sdo_o),
        .sync_o(sync_o), .pins_en_o(pins_en_o), .tx_busy_o(tx_busy_o)
    );

    // {result, coding, rdc, div, pol, expected word, expected half}
    localparam int NV = 6;
    localparam logic [45:0] VEC [NV] = '{
        {18'h2A5C3, 1'b1, 1'b0, 2'd0, 1'b0, 18'h2A5C3, 5'd2},
        {18'h2A5C3, 1'b0, 1'b0, 2'd1, 1'b1, 18'h0A5C3, 5'd4},
        {18'h00001, 1'b0, 1'b0, 2'd2, 1'b0, 18'h20001, 5'd8},
        {18'h3FFFF, 1'b1, 1'b0, 2'd3, 1'b1, 18'h3FFFF, 5'd16},
        {18'h1234F, 1'b1, 1'b1, 2'd3, 1'b0, 18'h1234F, 5'd2},
        {18'h30F0F, 1'b0, 1'b1, 2'd1, 1'b1, 18'h10F0F, 5'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // observe one frame; the start edge is the one just before this call
    task automatic observe(input logic [17:0] exp_word, input int h, input bit inject);
        logic [17:0] got = '0;
        int rises = 0, first_rise = -1, last_rise = -1, bad_period = 0;
        int sync_cnt = 0, unstable = 0;
        logic prev_sclk = 1'b0, prev_sdo;
        prev_sdo = sdo_o;
        check(tx_busy_o == 1'b1, "R10 busy at start", tx_busy_o, 1);
        for (int j = 0; j < 1000; j++) begin
            if (sync_o == sync_pol_i) break;
            sync_cnt++;
            if (sclk_o && !prev_sclk) begin
                got = {got[16:0], sdo_o};
                if (first_rise < 0) first_rise = j;
                else if (j - last_rise != 2 * h) bad_period++;
                last_rise = j;
                rises++;
            end
            if (j > 0 && sclk_o != prev_sclk && sdo_o != prev_sdo) unstable++;
            prev_sclk = sclk_o;
            prev_sdo  = sdo_o;
            if (inject && j == 5) begin
                result_i = 18'h0F0F0; result_valid_i = 1'b1; conv_start_i = 1'b1;
            end else begin
                result_valid_i = 1'b0; conv_start_i = 1'b0;
            end
            @(negedge clk);
        end
        check(got == exp_word, "R1/R2 word", got, exp_word);
        check(rises == 18, "R1 rise count", rises, 18);
        check(first_rise == h, "R3 first rise", first_rise, h);
        check(bad_period == 0, "R6/R7 period", bad_period, 0);
        check(sync_cnt == 37 * h, "R3 sync length", sync_cnt, 37 * h);
        check(unstable == 0, "R8 data stable", unstable, 0);
        check(sclk_o == 1'b0 && tx_busy_o == 1'b0, "R1 end idle", sclk_o, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R11 reset state
        check(sclk_o == 1'b0, "R11 sclk", sclk_o, 0);
        check(tx_busy_o == 1'b0, "R11 busy", tx_busy_o, 0);
        check(sync_o == 1'b0, "R11 sync idle", sync_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11/R4 stored result is zero after reset
        rdc_i = 1'b1; coding_i = 1'b1; result_i = 18'h3FFFF; conv_start_i = 1'b1;
        @(negedge clk);
        conv_start_i = 1'b0;
        observe(18'h00000, 2, 1'b0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [45:0] e;
            e = VEC[v];
            repeat (2) @(negedge clk);
            coding_i = e[27]; rdc_i = e[26]; div_i = e[25:24]; sync_pol_i = e[23];
            result_i = e[45:28]; result_valid_i = 1'b1;
            if (e[26]) begin
                // R4: stores only, sent at next conversion start
                @(negedge clk);
                result_valid_i = 1'b0; result_i = 18'h15555;
                check(tx_busy_o == 1'b0, "R4 no frame on result", tx_busy_o, 0);
                conv_start_i = 1'b1;
            end
            @(negedge clk);
            result_valid_i = 1'b0; conv_start_i = 1'b0;
            observe(e[22:5], int'(e[4:0]), 1'b0);
        end

        // R5: conversion start ignored in read-after-convert
        rdc_i = 1'b0; sync_pol_i = 1'b0; conv_start_i = 1'b1;
        @(negedge clk);
        conv_start_i = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_busy_o == 1'b0, "R5 conv start ignored", tx_busy_o, 0);

        // R10: retrigger mid-frame ignored
        coding_i = 1'b1; div_i = 2'd0; result_i = 18'h2C3A5; result_valid_i = 1'b1;
        @(negedge clk);
        result_valid_i = 1'b0;
        observe(18'h2C3A5, 2, 1'b1);

        // R9: chip select high
        cs_n_i = 1'b1;
        @(negedge clk);
        check(pins_en_o == 1'b0, "R9 outputs released", pins_en_o, 0);
        result_valid_i = 1'b1; result_i = 18'h11111;
        @(negedge clk);
        result_valid_i = 1'b0;
        repeat (4) @(negedge clk);
        check(tx_busy_o == 1'b0 && sclk_o == 1'b0, "R9 start ignored", tx_busy_o, 0);
        check(sync_o == sync_pol_i, "R9 sync idle", sync_o, sync_pol_i);
        cs_n_i = 1'b0;
        @(negedge clk);
        check(pins_en_o == 1'b1, "R9 outputs driven", pins_en_o, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule